// File: doc/BRIEF.md
# Panel Register Init Sequencer

This block configures a small TFT display controller by writing its registers over a four-wire serial link. It holds a compiled command table. Each entry is an 8-bit register index, a 16-bit value and a wait in milliseconds. The block plays back parts of that table. Every register write goes out as two chip-select transactions of 24 bits each. The first frame selects the register and the second frame carries the value. After the two frames the block waits the wait time of the entry, then moves to the next entry.

When reset is released the block runs the start-up configuration. The interface-switch entries follow directly after it. The block then records the panel as powered. After that, a power request level chooses between a power-up sequence and a power-down sequence. A sequence is started only while the block is idle, and only when the requested level differs from the recorded state. Serial mode 0 is used: the clock idles low, the receiver samples on the rising edge, and the most significant bit goes first.

Top module: `panel_init_seq`

## Requirements
- R1: A register-select frame is 24 bits with chip select held low throughout: 0x70, then 0x00, then the register index. The clock idles low, data is sampled on the rising clock edge, and the most significant bit goes first.
- R2: The frame after a register-select frame is a value frame: 0x72, then the high byte of the value, then the low byte.
- R3: Chip select stays high for at least one serial clock period (2*SCLK_HALF_DIV system cycles) between any two frames. The serial clock is low whenever chip select is high.
- R4: After the value frame of an entry with a wait of D ms, the next frame or the end of the sequence comes no sooner than D*TICKS cycles and no later than 16 cycles after that. A zero wait moves on at once.
- R5: After reset the block runs 47 start-up entries, the last one writing 0x0133 to register 0x07. The start-up entries include 0x13=0x0000 with a 200 ms wait, 0x12=0x01BB with a 50 ms wait and 0x29=0x0010 with a 50 ms wait, and every other start-up entry has no wait. The four switch entries follow with no idle cycle: 0x03=0x1080, 0x20=0x0000, 0x21=0x0000, then 0x0C=0x0111 with a 500 ms wait.
- R6: The power-down sequence writes 0x07=0x0131 (100 ms), 0x07=0x0130 (100 ms), 0x07=0x0100, 0x10=0x0280 and 0x12=0x018B.
- R7: The power-up sequence writes 0x10=0x1280, 0x07=0x0101 (100 ms), 0x07=0x0121, 0x07=0x0123 (100 ms) and 0x07=0x0133 (10 ms).
- R8: A request level (1 = on) equal to the recorded power state causes no serial traffic, and busy stays low.
- R9: The request is looked at only while the block is idle. Changes during a sequence take effect after it ends, and the latest level wins.
- R10: Busy is high from sequence start until the last wait has elapsed. Done is a one-cycle pulse at the end of each sequence, and the start-up and switch entries together count as one sequence. The power state output changes only with done: it goes to 1 after start-up and to the requested level after a power sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Requested power level, 1 = on |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data, MSB first |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| panel_on | output | 1 | Recorded power state |

## Verification
The start-up run is checked at three points: its fixed entries, its entry count and the exact switch tail. This shows whether the table order and the start-up-to-switch hand-off are right. Directed requests then cover the cases that must be told apart. A request equal to the recorded state must produce no traffic. A lone toggle must run exactly one sequence. A toggle and its reversal inside one sequence must leave the latest level in control. Random request levels, held for random spans both shorter and longer than a sequence, are compared against a bench model of the power state. Each decoded entry is compared with the expected table, and every wait is measured in cycles. This separates correct waits from skipped waits and from waits applied to the wrong entry.

// File: rtl/pnlseq_pkg.sv
package pnlseq_pkg;

    localparam int PTR_W = 6;
    localparam int DLY_W = 10;

    localparam logic [7:0] HDR_SELECT = 8'h70;
    localparam logic [7:0] HDR_VALUE  = 8'h72;

    localparam int BOOT_FIRST = 0;
    localparam int BOOT_LAST  = 50;
    localparam int UP_FIRST   = 51;
    localparam int UP_LAST    = 55;
    localparam int DOWN_FIRST = 56;
    localparam int DOWN_LAST  = 60;

    typedef struct packed {
        logic [7:0]       reg_idx;
        logic [15:0]      value;
        logic [DLY_W-1:0] wait_ms;
    } cmd_t;

    typedef enum logic [2:0] {
        C_IDLE, C_SEL_GO, C_SEL_WAIT, C_VAL_GO, C_VAL_WAIT, C_DLY_GO, C_DLY_WAIT
    } ctl_state_t;

    function automatic cmd_t mk(input logic [7:0] r, input logic [15:0] v, input int d);
        cmd_t c;
        c.reg_idx = r;
        c.value   = v;
        c.wait_ms = DLY_W'(d);
        return c;
    endfunction

    // Command table: start-up 0..46, switch 47..50, power-up 51..55, power-down 56..60
    function automatic cmd_t rom_entry(input logic [PTR_W-1:0] a);
        case (a)
            6'd0:  return mk(8'h01, 16'h0000, 0);
            6'd1:  return mk(8'h02, 16'h0700, 0);
            6'd2:  return mk(8'h03, 16'h50A0, 0);
            6'd3:  return mk(8'h04, 16'h0000, 0);
            6'd4:  return mk(8'h08, 16'h0606, 0);
            6'd5:  return mk(8'h09, 16'h0000, 0);
            6'd6:  return mk(8'h0A, 16'h0000, 0);
            6'd7:  return mk(8'h0C, 16'h0000, 0);
            6'd8:  return mk(8'h0D, 16'h0000, 0);
            6'd9:  return mk(8'h0F, 16'h0002, 0);
            6'd10: return mk(8'h11, 16'h0007, 0);
            6'd11: return mk(8'h12, 16'h0000, 0);
            6'd12: return mk(8'h13, 16'h0000, 200);
            6'd13: return mk(8'h07, 16'h0101, 0);
            6'd14: return mk(8'h10, 16'h12B0, 0);
            6'd15: return mk(8'h11, 16'h0007, 0);
            6'd16: return mk(8'h12, 16'h01BB, 50);
            6'd17: return mk(8'h13, 16'h0013, 0);
            6'd18: return mk(8'h29, 16'h0010, 50);
            6'd19: return mk(8'h30, 16'h000A, 0);
            6'd20: return mk(8'h31, 16'h1326, 0);
            6'd21: return mk(8'h32, 16'h0A29, 0);
            6'd22: return mk(8'h35, 16'h0A0A, 0);
            6'd23: return mk(8'h36, 16'h1E03, 0);
            6'd24: return mk(8'h37, 16'h031E, 0);
            6'd25: return mk(8'h38, 16'h0706, 0);
            6'd26: return mk(8'h39, 16'h0303, 0);
            6'd27: return mk(8'h3C, 16'h010E, 0);
            6'd28: return mk(8'h3D, 16'h040E, 0);
            6'd29: return mk(8'h50, 16'h0000, 0);
            6'd30: return mk(8'h51, 16'h00EF, 0);
            6'd31: return mk(8'h52, 16'h0000, 0);
            6'd32: return mk(8'h53, 16'h013F, 0);
            6'd33: return mk(8'h60, 16'h2700, 0);
            6'd34: return mk(8'h61, 16'h0001, 0);
            6'd35: return mk(8'h6A, 16'h0000, 0);
            6'd36: return mk(8'h80, 16'h0000, 0);
            6'd37: return mk(8'h81, 16'h0000, 0);
            6'd38: return mk(8'h82, 16'h0000, 0);
            6'd39: return mk(8'h83, 16'h0000, 0);
            6'd40: return mk(8'h84, 16'h0000, 0);
            6'd41: return mk(8'h85, 16'h0000, 0);
            6'd42: return mk(8'h90, 16'h0010, 0);
            6'd43: return mk(8'h92, 16'h0000, 0);
            6'd44: return mk(8'h95, 16'h0210, 0);
            6'd45: return mk(8'h97, 16'h0000, 0);
            6'd46: return mk(8'h07, 16'h0133, 0);
            6'd47: return mk(8'h03, 16'h1080, 0);
            6'd48: return mk(8'h20, 16'h0000, 0);
            6'd49: return mk(8'h21, 16'h0000, 0);
            6'd50: return mk(8'h0C, 16'h0111, 500);
            6'd51: return mk(8'h10, 16'h1280, 0);
            6'd52: return mk(8'h07, 16'h0101, 100);
            6'd53: return mk(8'h07, 16'h0121, 0);
            6'd54: return mk(8'h07, 16'h0123, 100);
            6'd55: return mk(8'h07, 16'h0133, 10);
            6'd56: return mk(8'h07, 16'h0131, 100);
            6'd57: return mk(8'h07, 16'h0130, 100);
            6'd58: return mk(8'h07, 16'h0100, 0);
            6'd59: return mk(8'h10, 16'h0280, 0);
            6'd60: return mk(8'h12, 16'h018B, 0);
            default: return mk(8'h00, 16'h0000, 0);
        endcase
    endfunction

    function automatic logic [23:0] select_frame(input cmd_t c);
        return {HDR_SELECT, 8'h00, c.reg_idx};
    endfunction

    function automatic logic [23:0] value_frame(input cmd_t c);
        return {HDR_VALUE, c.value};
    endfunction

endpackage

// File: rtl/pnlseq_spi_tx.sv
module pnlseq_spi_tx #(
    parameter int HALF_DIV = 2,
    parameter int FRAME_W  = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               tx_done,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi
);
    localparam int CW = $clog2(2 * HALF_DIV) + 1;
    localparam int BW = $clog2(FRAME_W) + 1;

    typedef enum logic [1:0] {T_IDLE, T_SHIFT, T_GAP} tx_state_t;

    tx_state_t          st;
    logic [FRAME_W-1:0] sh;
    logic [BW-1:0]      bitn;
    logic [CW-1:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= T_IDLE;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            sh      <= '0;
            bitn    <= '0;
            cnt     <= '0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    sh   <= frame;
                    cs_n <= 1'b0;
                    cnt  <= '0;
                    bitn <= '0;
                    st   <= T_SHIFT;
                end
                T_SHIFT: if (cnt == CW'(HALF_DIV - 1)) begin
                    cnt  <= '0;
                    sclk <= ~sclk;
                    if (sclk) begin
                        if (bitn == BW'(FRAME_W - 1)) begin
                            cs_n <= 1'b1;
                            st   <= T_GAP;
                        end else begin
                            sh   <= sh << 1;
                            bitn <= bitn + 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
                T_GAP: if (cnt == CW'(2 * HALF_DIV - 1)) begin
                    cnt     <= '0;
                    tx_done <= 1'b1;
                    st      <= T_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign mosi = sh[FRAME_W-1];

    p_sclk_low_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    p_cs_holds_high_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);
    p_bits_bounded_r1: assert property (@(posedge clk) disable iff (rst)
        bitn < BW'(FRAME_W));
endmodule

// File: rtl/pnlseq_ms_timer.sv
module pnlseq_ms_timer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int DLY_W        = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] ms,
    output logic             expired
);
    localparam int PW = $clog2(TICKS_PER_MS + 1);

    logic [PW-1:0]    pre;
    logic [DLY_W-1:0] left;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre     <= '0;
            left    <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (start) begin
                run  <= 1'b1;
                pre  <= '0;
                left <= ms;
            end else if (run) begin
                if (pre == PW'(TICKS_PER_MS - 1)) begin
                    pre <= '0;
                    if (left == DLY_W'(1)) begin
                        run     <= 1'b0;
                        expired <= 1'b1;
                    end else begin
                        left <= left - 1'b1;
                    end
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end

    p_start_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> (ms != '0));
    p_start_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);
endmodule

// File: rtl/pnlseq_ctrl.sv
module pnlseq_ctrl
    import pnlseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic             tx_done,
    input  logic             tmr_expired,
    output logic             tx_start,
    output logic [23:0]      tx_frame,
    output logic             tmr_start,
    output logic [DLY_W-1:0] tmr_ms,
    output logic             busy,
    output logic             done,
    output logic             panel_on
);
    ctl_state_t       st;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] last;
    logic             target;
    cmd_t             cur;
    logic             entry_end;

    assign cur       = rom_entry(ptr);
    assign entry_end = ((st == C_DLY_GO) && (cur.wait_ms == '0)) ||
                       ((st == C_DLY_WAIT) && tmr_expired);
    assign busy      = (st != C_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= C_SEL_GO;
            ptr       <= PTR_W'(BOOT_FIRST);
            last      <= PTR_W'(BOOT_LAST);
            target    <= 1'b1;
            panel_on  <= 1'b0;
            done      <= 1'b0;
            tx_start  <= 1'b0;
            tx_frame  <= '0;
            tmr_start <= 1'b0;
            tmr_ms    <= '0;
        end else begin
            tx_start  <= 1'b0;
            tmr_start <= 1'b0;
            done      <= 1'b0;
            case (st)
                C_IDLE: if (pwr_req != panel_on) begin
                    target <= pwr_req;
                    ptr    <= pwr_req ? PTR_W'(UP_FIRST) : PTR_W'(DOWN_FIRST);
                    last   <= pwr_req ? PTR_W'(UP_LAST)  : PTR_W'(DOWN_LAST);
                    st     <= C_SEL_GO;
                end
                C_SEL_GO: begin
                    tx_start <= 1'b1;
                    tx_frame <= select_frame(cur);
                    st       <= C_SEL_WAIT;
                end
                C_SEL_WAIT: if (tx_done) st <= C_VAL_GO;
                C_VAL_GO: begin
                    tx_start <= 1'b1;
                    tx_frame <= value_frame(cur);
                    st       <= C_VAL_WAIT;
                end
                C_VAL_WAIT: if (tx_done) st <= C_DLY_GO;
                C_DLY_GO: if (cur.wait_ms != '0) begin
                    tmr_start <= 1'b1;
                    tmr_ms    <= cur.wait_ms;
                    st        <= C_DLY_WAIT;
                end
                default: ;
            endcase
            if (entry_end) begin
                if (ptr == last) begin
                    st       <= C_IDLE;
                    done     <= 1'b1;
                    panel_on <= target;
                end else begin
                    ptr <= ptr + 1'b1;
                    st  <= C_SEL_GO;
                end
            end
        end
    end

    p_idle_no_launch_r8: assert property (@(posedge clk) disable iff (rst)
        (st == C_IDLE) |=> !tx_start);
    p_ptr_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        ptr <= last);
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq #(
    parameter int CLK_HZ           = 100_000_000,
    parameter int SIM_TICKS_PER_MS = 0,
    parameter int SCLK_HALF_DIV    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req,
    output logic spi_sclk,
    output logic spi_cs_n,
    output logic spi_mosi,
    output logic busy,
    output logic done,
    output logic panel_on
);
    import pnlseq_pkg::*;

    localparam int TICKS = (SIM_TICKS_PER_MS > 0) ? SIM_TICKS_PER_MS : (CLK_HZ / 1000);

    logic             tx_start;
    logic [23:0]      tx_frame;
    logic             tx_done;
    logic             tmr_start;
    logic [DLY_W-1:0] tmr_ms;
    logic             tmr_expired;

    pnlseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .pwr_req(pwr_req),
        .tx_done(tx_done), .tmr_expired(tmr_expired),
        .tx_start(tx_start), .tx_frame(tx_frame),
        .tmr_start(tmr_start), .tmr_ms(tmr_ms),
        .busy(busy), .done(done), .panel_on(panel_on)
    );

    pnlseq_spi_tx #(.HALF_DIV(SCLK_HALF_DIV), .FRAME_W(24)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .frame(tx_frame),
        .tx_done(tx_done), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
    );

    pnlseq_ms_timer #(.TICKS_PER_MS(TICKS), .DLY_W(DLY_W)) u_tmr (
        .clk(clk), .rst(rst), .start(tmr_start), .ms(tmr_ms),
        .expired(tmr_expired)
    );

    p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    p_state_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        (panel_on != $past(panel_on)) |-> done);
endmodule

// File: tb/sim_panel_init_seq.sv
module sim_panel_init_seq;
    localparam int TPM  = 4;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 1'b1;
    logic spi_sclk, spi_cs_n, spi_mosi, busy, done, panel_on;

    always #2 clk = ~clk;

    panel_init_seq #(.CLK_HZ(250_000_000), .SIM_TICKS_PER_MS(TPM), .SCLK_HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .pwr_req(pwr_req),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .busy(busy), .done(done), .panel_on(panel_on)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // mode: 0 start-up, 1 power-up, 2 power-down; returns {idx, value, wait}
    function automatic logic [39:0] tbl(input int mode, input int k);
        if (mode == 0) begin
            case (k)
                0: return {8'h03, 16'h1080, 16'd0};
                1: return {8'h20, 16'h0000, 16'd0};
                2: return {8'h21, 16'h0000, 16'd0};
                default: return {8'h0C, 16'h0111, 16'd500};
            endcase
        end else if (mode == 1) begin
            case (k)
                0: return {8'h10, 16'h1280, 16'd0};
                1: return {8'h07, 16'h0101, 16'd100};
                2: return {8'h07, 16'h0121, 16'd0};
                3: return {8'h07, 16'h0123, 16'd100};
                default: return {8'h07, 16'h0133, 16'd10};
            endcase
        end else begin
            case (k)
                0: return {8'h07, 16'h0131, 16'd100};
                1: return {8'h07, 16'h0130, 16'd100};
                2: return {8'h07, 16'h0100, 16'd0};
                3: return {8'h10, 16'h0280, 16'd0};
                default: return {8'h12, 16'h018B, 16'd0};
            endcase
        end
    endfunction

    function automatic int startup_wait(input logic [7:0] r, input logic [15:0] v);
        if (r == 8'h13 && v == 16'h0000) return 200;
        if (r == 8'h12 && v == 16'h01BB) return 50;
        if (r == 8'h29 && v == 16'h0010) return 50;
        return 0;
    endfunction

    // monitor state
    longint cyc = 0;
    longint rise_cyc = 0;
    bit rise_seen = 0;
    bit prev_cs = 1, prev_sclk = 0;
    logic [23:0] shreg;
    int nbits = 0;
    bit expect_sel = 1;
    logic [7:0] cur_idx;
    int frame_cnt = 0;
    int done_cnt = 0;
    int seq_k = 0;
    int mode = 0;
    bit model_on = 0;
    bit pend_valid = 0;
    int pend_wait = 0;
    int seen_waits = 0;

    task automatic check_wait(input string tag);
        longint gap = cyc - rise_cyc;
        longint lo = longint'(pend_wait) * TPM;
        chk(gap >= lo && gap <= lo + 16, "R4", tag, gap, lo);
        pend_valid = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_cs = 1; prev_sclk = 0; nbits = 0; expect_sel = 1;
        end else begin
            if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                shreg = {shreg[22:0], spi_mosi};
                nbits++;
            end
            if (prev_cs && !spi_cs_n) begin
                if (rise_seen) chk(cyc - rise_cyc >= 2 * HALF, "R3", "cs high gap", cyc - rise_cyc, 2 * HALF);
                if (expect_sel && pend_valid) check_wait("wait before next entry");
                nbits = 0;
                shreg = '0;
            end
            if (!spi_cs_n == 1'b0 && spi_sclk) chk(0, "R3", "sclk high with cs high", 1, 0);
            if (!prev_cs && spi_cs_n) begin
                rise_cyc = cyc;
                rise_seen = 1;
                frame_cnt++;
                chk(nbits == 24, "R1", "bits per frame", nbits, 24);
                if (expect_sel) begin
                    chk(shreg[23:8] == 16'h7000, "R1", "select header", shreg[23:8], 16'h7000);
                    cur_idx = shreg[7:0];
                end else begin
                    logic [39:0] e;
                    chk(shreg[23:16] == 8'h72, "R2", "value header", shreg[23:16], 8'h72);
                    if (mode == 0) begin
                        if (seq_k >= 47) begin
                            e = tbl(0, seq_k - 47);
                            chk({cur_idx, shreg[15:0]} == e[39:16], "R5", "switch entry", {cur_idx, shreg[15:0]}, e[39:16]);
                            pend_wait = int'(e[15:0]);
                        end else begin
                            if (seq_k == 46)
                                chk({cur_idx, shreg[15:0]} == 24'h070133, "R5", "last start-up entry", {cur_idx, shreg[15:0]}, 24'h070133);
                            pend_wait = startup_wait(cur_idx, shreg[15:0]);
                            if (pend_wait != 0) seen_waits++;
                        end
                    end else begin
                        e = tbl(mode, seq_k);
                        chk(seq_k < 5 && {cur_idx, shreg[15:0]} == e[39:16], mode == 1 ? "R7" : "R6",
                            "sequence entry", {cur_idx, shreg[15:0]}, e[39:16]);
                        pend_wait = int'(e[15:0]);
                    end
                    pend_valid = 1;
                    seq_k++;
                end
                expect_sel = !expect_sel;
            end
            if (done) begin
                done_cnt++;
                if (pend_valid) check_wait("wait before done");
                if (mode == 0) begin
                    chk(seq_k == 51, "R5", "start-up entry count", seq_k, 51);
                    chk(seen_waits == 3, "R5", "start-up waits found", seen_waits, 3);
                    model_on = 1;
                end else begin
                    chk(seq_k == 5, mode == 1 ? "R7" : "R6", "entry count", seq_k, 5);
                    model_on = (mode == 1);
                end
                chk(panel_on == model_on, "R10", "power state at done", panel_on, model_on);
                chk(!busy, "R10", "busy low at done", busy, 0);
                mode = model_on ? 2 : 1;
                seq_k = 0;
            end
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    task automatic settle();
        int quiet = 0;
        while (quiet < 30) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int unsigned seed = 32'd4711;
        int f0, d0;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R3", "cs idle in reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R3", "sclk low in reset", spi_sclk, 0);
        chk(done == 1'b0, "R10", "done low in reset", done, 0);
        chk(panel_on == 1'b0, "R10", "power state in reset", panel_on, 0);
        @(posedge clk); rst <= 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R5", "start-up begins after reset", busy, 1);
        while (done_cnt < 1) @(negedge clk);
        chk(panel_on == 1'b1, "R5", "on after start-up", panel_on, 1);

        // request equal to state: nothing happens
        f0 = frame_cnt;
        repeat (400) @(negedge clk);
        chk(frame_cnt == f0, "R8", "frames with matching request", frame_cnt - f0, 0);
        chk(busy == 1'b0, "R8", "busy with matching request", busy, 0);

        // single toggle to off
        d0 = done_cnt;
        pwr_req = 1'b0;
        settle();
        chk(done_cnt == d0 + 1, "R6", "one power-down run", done_cnt - d0, 1);
        chk(panel_on == 1'b0, "R10", "state off", panel_on, 0);

        // toggle and reverse within one sequence: latest level wins
        d0 = done_cnt;
        pwr_req = 1'b1;
        repeat (60) @(negedge clk);
        pwr_req = 1'b0;
        repeat (60) @(negedge clk);
        pwr_req = 1'b1;
        settle();
        chk(done_cnt == d0 + 1, "R9", "reversal inside run", done_cnt - d0, 1);
        chk(panel_on == 1'b1, "R9", "latest level held", panel_on, 1);

        // toggle during busy: latest request serviced after completion
        d0 = done_cnt;
        pwr_req = 1'b0;
        repeat (80) @(negedge clk);
        pwr_req = 1'b1;
        settle();
        chk(done_cnt == d0 + 2, "R9", "deferred request run", done_cnt - d0, 2);
        chk(panel_on == 1'b1, "R9", "state after deferred run", panel_on, 1);

        // random levels with random hold times
        for (int i = 0; i < 12; i++) begin
            pwr_req = 1'($urandom % 2);
            repeat ($urandom % 2500 + 20) @(negedge clk);
        end
        settle();
        chk(panel_on == pwr_req, "R9", "final state follows request", panel_on, pwr_req);
        chk(panel_on == model_on, "R10", "state matches model", panel_on, model_on);
        f0 = frame_cnt;
        repeat (300) @(negedge clk);
        chk(frame_cnt == f0, "R8", "quiet after settle", frame_cnt - f0, 0);
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog: busy %0d expected 0", busy);
            summary();
        end
    end
endmodule